// File: doc/BRIEF.md
# Predicate branch condition evaluator

This block decides, for every fiber of a SIMD core, whether a branch is taken. Each fiber carries four predicate component bits. Up to two condition sources are formed by picking one component with a 2-bit selector and optionally inverting it. A 3-bit branch kind code then says how the sources become a per-fiber taken mask. The mask can come from one source alone, from two sources combined by OR or by AND, or from a cross-fiber reduction (any or all) that yields one uniform answer for the whole group. Two kinds, indexed and indirect, take no predicate at all.

The result is registered once. A request presented with `in_valid` high in one cycle appears on the outputs, with `out_valid` high, after the next rising clock edge. Fibers outside the active mask never appear as taken. A reserved kind code produces an empty mask and raises `illegal_type`. Target address arithmetic and the execution-mask update belong to neighbouring logic.

Top module: `pred_branch_eval`

## Requirements
- R1: Outputs are registered with one cycle of latency. `out_valid` equals `in_valid` of the previous cycle. While reset (`rst_n` low, synchronous) is applied, and in any cycle after an idle input cycle, `out_valid`, `taken_mask`, `uniform_taken` and `illegal_type` are all zero.
- R2: Source A reads the component of fiber f at `pred_bits[f*4 + src_a_sel]` (component 0 is x, 3 is w) and XORs it with `src_a_inv`. Source B does the same with `src_b_sel` and `src_b_inv`.
- R3: Kind 3'b000 (single): a fiber is taken when it is active and source A is true.
- R4: Kind 3'b001 takes active fibers where source A OR source B is true. Kind 3'b010 takes active fibers where source A AND source B is true.
- R5: Kind 3'b100 (any): `uniform_taken` is set when source A is true in at least one active fiber. The mask then equals the active mask, and is zero otherwise.
- R6: Kind 3'b101 (all): `uniform_taken` is set when source A is true in every active fiber and at least one fiber is active. The mask follows the same rule as R5. With no active fibers, the result is false.
- R7: Kinds 3'b011 (indexed) and 3'b110 (indirect) report the whole active mask as taken, whatever the sources hold. `uniform_taken` stays 0.
- R8: An inactive fiber is never set in `taken_mask`, for any kind.
- R9: Kind 3'b111 is reserved. It yields an all-zero mask, `uniform_taken` 0 and `illegal_type` 1. Every other kind leaves `illegal_type` at 0.
- R10: `uniform_taken` is 0 for every kind other than 3'b100 and 3'b101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A branch request is presented this cycle |
| br_kind | input | 3 | Branch kind code |
| src_a_sel | input | 2 | Component selector of source A |
| src_a_inv | input | 1 | Invert source A |
| src_b_sel | input | 2 | Component selector of source B |
| src_b_inv | input | 1 | Invert source B |
| pred_bits | input | NUM_FIBERS*4 | Predicate components, 4 per fiber, fiber 0 lowest |
| active_mask | input | NUM_FIBERS | Active fibers |
| out_valid | output | 1 | Result valid |
| taken_mask | output | NUM_FIBERS | Per-fiber taken result |
| uniform_taken | output | 1 | Uniform result of any/all kinds |
| illegal_type | output | 1 | Reserved kind code seen |

## Verification
The bench builds the block with eight fibers. Eight is enough to mix true and false components in different lanes, so selector, inversion and OR/AND differences show up as distinct mask bits. It also allows partial, full and empty active masks. The empty mask brings the all-with-no-fibers corner of R6 within reach. The full and partial masks tell "true in every active fiber" apart from "true in every fiber".

// File: rtl/pbe_pkg.sv
// Package: shared kind codes and sizing constants for the predicate
// branch condition evaluator. Assumes four predicate components per fiber.
package pbe_pkg;
    localparam int PRED_COMPS = 4;
    localparam int SEL_W      = $clog2(PRED_COMPS);

    typedef enum logic [2:0] {
        BK_SINGLE   = 3'b000,
        BK_OR2      = 3'b001,
        BK_AND2     = 3'b010,
        BK_INDEXED  = 3'b011,
        BK_ANY      = 3'b100,
        BK_ALL      = 3'b101,
        BK_INDIRECT = 3'b110,
        BK_RSVD     = 3'b111
    } br_kind_e;
endpackage

// File: rtl/pbe_src_pick.sv
// Module: per-fiber condition source. For each fiber, selects one predicate
// component and applies the optional inversion. Pure combinational logic.
// Assumes the components of fiber f occupy bits [f*COMPS +: COMPS].
module pbe_src_pick #(
    parameter int NUM_FIBERS = 8,
    parameter int COMPS      = 4,
    localparam int SEL_W     = $clog2(COMPS)
) (
    input  logic [NUM_FIBERS*COMPS-1:0] pred_bits,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        inv,
    output logic [NUM_FIBERS-1:0]       cond
);
    genvar f;
    generate
        for (f = 0; f < NUM_FIBERS; f++) begin : g_fiber
            logic [COMPS-1:0] comps;
            // Slice out this fiber's components.
            assign comps   = pred_bits[f*COMPS +: COMPS];
            // Pick the selected component and apply the inversion.
            assign cond[f] = comps[sel] ^ inv;
        end
    endgenerate
endmodule

// File: rtl/pbe_reduce.sv
// Module: cross-fiber reduction over the active fibers. any_hit is set when
// some active fiber holds a true condition. all_hit is set when every active
// fiber does and at least one fiber is active. Combinational.
module pbe_reduce #(
    parameter int NUM_FIBERS = 8
) (
    input  logic [NUM_FIBERS-1:0] cond,
    input  logic [NUM_FIBERS-1:0] active,
    output logic                  any_hit,
    output logic                  all_hit
);
    logic some_active;

    // Form the reductions; inactive lanes are forced neutral for each.
    always_comb begin
        some_active = |active;
        any_hit     = |(cond & active);
        all_hit     = some_active && (&(cond | ~active));
    end
endmodule

// File: rtl/pbe_combine.sv
// Module: turns the source conditions and reductions into the next taken
// mask, uniform flag and illegal flag according to the branch kind.
// Combinational. Assumes cond inputs are already per-fiber booleans.
module pbe_combine
    import pbe_pkg::*;
#(
    parameter int NUM_FIBERS = 8
) (
    input  br_kind_e              kind,
    input  logic [NUM_FIBERS-1:0] cond_a,
    input  logic [NUM_FIBERS-1:0] cond_b,
    input  logic [NUM_FIBERS-1:0] active,
    input  logic                  any_hit,
    input  logic                  all_hit,
    output logic [NUM_FIBERS-1:0] mask_nxt,
    output logic                  uniform_nxt,
    output logic                  illegal_nxt
);
    logic [NUM_FIBERS-1:0] raw;

    // Choose the raw per-fiber result and the flags for the given kind.
    always_comb begin
        raw         = '0;
        uniform_nxt = 1'b0;
        illegal_nxt = 1'b0;
        unique case (kind)
            BK_SINGLE:   raw = cond_a;
            BK_OR2:      raw = cond_a | cond_b;
            BK_AND2:     raw = cond_a & cond_b;
            BK_INDEXED,
            BK_INDIRECT: raw = '1;
            BK_ANY: begin
                uniform_nxt = any_hit;
                raw         = {NUM_FIBERS{any_hit}};
            end
            BK_ALL: begin
                uniform_nxt = all_hit;
                raw         = {NUM_FIBERS{all_hit}};
            end
            default:     illegal_nxt = 1'b1;
        endcase
    end

    // Only active fibers may ever be reported as taken.
    assign mask_nxt = raw & active;
endmodule

// File: rtl/pred_branch_eval.sv
// Module: top of the predicate branch condition evaluator. Builds two
// condition sources, reduces source A across active fibers, combines by
// branch kind and registers the result (one cycle latency).
// Assumes synchronous active-low reset; idle cycles clear the outputs.
module pred_branch_eval
    import pbe_pkg::*;
#(
    parameter int NUM_FIBERS = 8,
    localparam int PRED_W    = NUM_FIBERS * PRED_COMPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            br_kind,
    input  logic [SEL_W-1:0]      src_a_sel,
    input  logic                  src_a_inv,
    input  logic [SEL_W-1:0]      src_b_sel,
    input  logic                  src_b_inv,
    input  logic [PRED_W-1:0]     pred_bits,
    input  logic [NUM_FIBERS-1:0] active_mask,
    output logic                  out_valid,
    output logic [NUM_FIBERS-1:0] taken_mask,
    output logic                  uniform_taken,
    output logic                  illegal_type
);
    logic [NUM_FIBERS-1:0] cond_a;
    logic [NUM_FIBERS-1:0] cond_b;
    logic                  any_hit;
    logic                  all_hit;
    logic [NUM_FIBERS-1:0] mask_nxt;
    logic                  uniform_nxt;
    logic                  illegal_nxt;
    br_kind_e              kind;

    // Interpret the raw code as a branch kind.
    assign kind = br_kind_e'(br_kind);

    pbe_src_pick #(.NUM_FIBERS(NUM_FIBERS), .COMPS(PRED_COMPS)) u_src_a (
        .pred_bits (pred_bits),
        .sel       (src_a_sel),
        .inv       (src_a_inv),
        .cond      (cond_a)
    );

    pbe_src_pick #(.NUM_FIBERS(NUM_FIBERS), .COMPS(PRED_COMPS)) u_src_b (
        .pred_bits (pred_bits),
        .sel       (src_b_sel),
        .inv       (src_b_inv),
        .cond      (cond_b)
    );

    pbe_reduce #(.NUM_FIBERS(NUM_FIBERS)) u_reduce (
        .cond    (cond_a),
        .active  (active_mask),
        .any_hit (any_hit),
        .all_hit (all_hit)
    );

    pbe_combine #(.NUM_FIBERS(NUM_FIBERS)) u_combine (
        .kind        (kind),
        .cond_a      (cond_a),
        .cond_b      (cond_b),
        .active      (active_mask),
        .any_hit     (any_hit),
        .all_hit     (all_hit),
        .mask_nxt    (mask_nxt),
        .uniform_nxt (uniform_nxt),
        .illegal_nxt (illegal_nxt)
    );

    // Output register: capture a valid result, clear on reset or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid     <= 1'b0;
            taken_mask    <= '0;
            uniform_taken <= 1'b0;
            illegal_type  <= 1'b0;
        end else begin
            out_valid     <= 1'b1;
            taken_mask    <= mask_nxt;
            uniform_taken <= uniform_nxt;
            illegal_type  <= illegal_nxt;
        end
    end
endmodule

// File: rtl/pbe_checker.sv
// Module: assertion checker for pred_branch_eval, attached by bind.
// Relates registered outputs to the inputs of the previous cycle.
module pbe_checker #(
    parameter int NUM_FIBERS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [2:0]              br_kind,
    input logic [NUM_FIBERS-1:0]   active_mask,
    input logic                    out_valid,
    input logic [NUM_FIBERS-1:0]   taken_mask,
    input logic                    uniform_taken,
    input logic                    illegal_type
);
    // R1: valid follows the request by one cycle.
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R1: an idle output carries no result.
    assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (taken_mask == '0 && !uniform_taken && !illegal_type));

    // R8: no inactive fiber is ever taken.
    assert_inactive_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((taken_mask & ~$past(active_mask)) == '0));

    // R9: the illegal flag marks exactly the reserved code, with an empty mask.
    assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (illegal_type == ($past(br_kind) == 3'b111)));
    assert_illegal_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal_type) |-> (taken_mask == '0 && !uniform_taken));

    // R7: indexed and indirect kinds take every active fiber.
    assert_nopred_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(br_kind) == 3'b011 || $past(br_kind) == 3'b110))
        |-> (taken_mask == $past(active_mask) && !uniform_taken));

    // R5: reductions apply one answer to all active fibers.
    assert_uniform_spread_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(br_kind) == 3'b100 || $past(br_kind) == 3'b101))
        |-> (taken_mask == (uniform_taken ? $past(active_mask) : '0)));

    // R6: "all" over an empty group is false.
    assert_all_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(br_kind) == 3'b101 && $past(active_mask) == '0)
        |-> !uniform_taken);

    // R10: no uniform answer outside the reduction kinds.
    assert_uniform_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(br_kind) != 3'b100 && $past(br_kind) != 3'b101)
        |-> !uniform_taken);
endmodule

bind pred_branch_eval pbe_checker #(.NUM_FIBERS(NUM_FIBERS)) u_pbe_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .br_kind       (br_kind),
    .active_mask   (active_mask),
    .out_valid     (out_valid),
    .taken_mask    (taken_mask),
    .uniform_taken (uniform_taken),
    .illegal_type  (illegal_type)
);

// File: tb/tb_pred_branch_eval.sv
`timescale 1ns/1ps
module tb_pred_branch_eval;
    localparam int NF = 8;
    localparam int PW = NF * 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    br_kind;
    logic [1:0]    src_a_sel;
    logic          src_a_inv;
    logic [1:0]    src_b_sel;
    logic          src_b_inv;
    logic [PW-1:0] pred_bits;
    logic [NF-1:0] active_mask;
    logic          out_valid;
    logic [NF-1:0] taken_mask;
    logic          uniform_taken;
    logic          illegal_type;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    pred_branch_eval #(.NUM_FIBERS(NF)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .br_kind(br_kind),
        .src_a_sel(src_a_sel), .src_a_inv(src_a_inv),
        .src_b_sel(src_b_sel), .src_b_inv(src_b_inv),
        .pred_bits(pred_bits), .active_mask(active_mask),
        .out_valid(out_valid), .taken_mask(taken_mask),
        .uniform_taken(uniform_taken), .illegal_type(illegal_type)
    );

    // Reference model written from the requirements: {illegal, uniform, mask}.
    function automatic logic [NF+1:0] model(input logic [2:0] k,
            input logic [1:0] asel, input logic ainv,
            input logic [1:0] bsel, input logic binv,
            input logic [PW-1:0] p, input logic [NF-1:0] act);
        logic [NF-1:0] ca, cb, m;
        logic anyv, allv, uni, ill;
        anyv = 1'b0; allv = 1'b1; uni = 1'b0; ill = 1'b0; m = '0;
        for (int f = 0; f < NF; f++) begin
            ca[f] = p[f*4 + asel] ^ ainv;
            cb[f] = p[f*4 + bsel] ^ binv;
            if (act[f]) begin
                anyv = anyv | ca[f];
                allv = allv & ca[f];
            end
        end
        if (act == '0) allv = 1'b0;
        case (k)
            3'b000: m = ca & act;
            3'b001: m = (ca | cb) & act;
            3'b010: m = (ca & cb) & act;
            3'b011, 3'b110: m = act;
            3'b100: begin uni = anyv; m = anyv ? act : '0; end
            3'b101: begin uni = allv; m = allv ? act : '0; end
            default: ill = 1'b1;
        endcase
        return {ill, uni, m};
    endfunction

    task automatic check(input string req, input logic [NF+2:0] act_v, input logic [NF+2:0] exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual {valid,illegal,uniform,mask}=%b expected %b", req, act_v, exp_v);
        end
    endtask

    // Present one request, wait one edge, compare against the model.
    task automatic run(input string req, input logic [2:0] k,
            input logic [1:0] asel, input logic ainv,
            input logic [1:0] bsel, input logic binv,
            input logic [PW-1:0] p, input logic [NF-1:0] act);
        @(negedge clk);
        in_valid = 1'b1; br_kind = k;
        src_a_sel = asel; src_a_inv = ainv; src_b_sel = bsel; src_b_inv = binv;
        pred_bits = p; active_mask = act;
        @(posedge clk); #1;
        check(req, {out_valid, illegal_type, uniform_taken, taken_mask},
              {1'b1, model(k, asel, ainv, bsel, binv, p, act)});
    endtask

    // Predicate pattern: component x = 8'b1010_1100 per fiber, y = 8'b0110_0110,
    // z = all ones, w = all zeros (fiber f bit taken from each byte).
    function automatic logic [PW-1:0] pat();
        logic [PW-1:0] p;
        logic [7:0] xs = 8'b1010_1100, ys = 8'b0110_0110;
        for (int f = 0; f < NF; f++) begin
            p[f*4+0] = xs[f]; p[f*4+1] = ys[f]; p[f*4+2] = 1'b1; p[f*4+3] = 1'b0;
        end
        return p;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset", {out_valid, illegal_type, uniform_taken, taken_mask}, '0);
    endtask

    task automatic t_single();
        run("R3 single x",       3'b000, 2'd0, 1'b0, 2'd0, 1'b0, pat(), 8'hFF);
        run("R2 select y",       3'b000, 2'd1, 1'b0, 2'd0, 1'b0, pat(), 8'hFF);
        run("R2 invert x",       3'b000, 2'd0, 1'b1, 2'd0, 1'b0, pat(), 8'hFF);
        run("R2 select w inv",   3'b000, 2'd3, 1'b1, 2'd0, 1'b0, pat(), 8'hFF);
    endtask

    task automatic t_two_src();
        run("R4 or x|y",         3'b001, 2'd0, 1'b0, 2'd1, 1'b0, pat(), 8'hFF);
        run("R4 and x&y",        3'b010, 2'd0, 1'b0, 2'd1, 1'b0, pat(), 8'hFF);
        run("R4 and x&!y",       3'b010, 2'd0, 1'b0, 2'd1, 1'b1, pat(), 8'hFF);
        run("R4 or !z|w",        3'b001, 2'd2, 1'b1, 2'd3, 1'b0, pat(), 8'hFF);
    endtask

    task automatic t_reduce();
        run("R5 any hit",        3'b100, 2'd0, 1'b0, 2'd0, 1'b0, pat(), 8'h0F);
        run("R5 any miss",       3'b100, 2'd0, 1'b0, 2'd0, 1'b0, pat(), 8'h53);
        run("R5 any none active",3'b100, 2'd2, 1'b0, 2'd0, 1'b0, pat(), 8'h00);
        run("R6 all partial",    3'b101, 2'd0, 1'b0, 2'd0, 1'b0, pat(), 8'hAC);
        run("R6 all full miss",  3'b101, 2'd0, 1'b0, 2'd0, 1'b0, pat(), 8'hFF);
        run("R6 all z",          3'b101, 2'd2, 1'b0, 2'd0, 1'b0, pat(), 8'hFF);
        run("R6 all none active",3'b101, 2'd2, 1'b0, 2'd0, 1'b0, pat(), 8'h00);
    endtask

    task automatic t_nopred();
        run("R7 indexed",        3'b011, 2'd3, 1'b0, 2'd3, 1'b0, pat(), 8'h5A);
        run("R7 indirect",       3'b110, 2'd3, 1'b0, 2'd3, 1'b0, '0,    8'hC3);
    endtask

    task automatic t_masking();
        run("R8 single masked",  3'b000, 2'd2, 1'b0, 2'd0, 1'b0, pat(), 8'h81);
        run("R8 or masked",      3'b001, 2'd2, 1'b0, 2'd2, 1'b0, pat(), 8'h3C);
        run("R10 single no uni", 3'b000, 2'd2, 1'b0, 2'd0, 1'b0, pat(), 8'hFF);
    endtask

    task automatic t_illegal();
        run("R9 reserved",       3'b111, 2'd2, 1'b0, 2'd2, 1'b0, pat(), 8'hFF);
        run("R9 legal after",    3'b000, 2'd2, 1'b0, 2'd0, 1'b0, pat(), 8'hFF);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; br_kind = 3'b011; active_mask = 8'hFF;
        @(posedge clk); #1;
        check("R1 idle clears", {out_valid, illegal_type, uniform_taken, taken_mask}, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; br_kind = 3'b011;
        src_a_sel = '0; src_a_inv = 1'b0; src_b_sel = '0; src_b_inv = 1'b0;
        pred_bits = '0; active_mask = 8'hFF;
        repeat (3) @(posedge clk);
        t_reset();
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        t_single();
        t_two_src();
        t_reduce();
        t_nopred();
        t_masking();
        t_illegal();
        t_idle();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule